// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block turns bytes into asynchronous serial frames on a single output line. A byte offered on the write port is held in a one-entry holding register. When the shifter is free, the byte moves into the shifter and goes out as one frame: a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then one or two high stop bits. The line rests high between frames.

Static inputs set the frame format, the bit period, the transmit gate, the output-enable gate and an optional clear-to-send gate. Two status flags feed interrupt logic. One says the holding register can take a byte. The other says the whole transmit path has drained.

Top module: `sertx_core`

## Requirements
- R1: After reset, `txd_o` is 1, `stat_o` is 2'b11 and no frame is in progress.
- R2: A frame is one start bit at 0, then data bits LSB first, then the parity bit if enabled, then the stop bits at 1. The line is 1 whenever no frame is in progress.
- R3: `len_code_i` selects the number of data bits: 2'd0 gives 8, 2'd1 gives 5, 2'd2 gives 6 and 2'd3 gives 7. Unused upper bits of the byte are not sent.
- R4: With `par_en_i`=1, a parity bit follows the data. With `par_odd_i`=0 it makes the count of ones in the sent data bits plus parity even, and with `par_odd_i`=1 it makes that count odd. With `par_en_i`=0 no parity bit is sent.
- R5: `two_stop_i`=1 sends two stop bits, and 0 sends one.
- R6: Each bit lasts `div_i`+1 clock cycles. The divisor is re-read at every bit boundary, so a divisor of 0 gives one-clock bits. A frame of N bits keeps the path busy for N*(`div_i`+1) cycles after it starts.
- R7: `txd_oe_o` follows `out_en_i`. While `out_en_i`=0, `txd_o` stays 1 even when a frame is shifting.
- R8: While `tx_en_i`=0, no frame starts and a written byte stays in the holding register. Once `tx_en_i` returns to 1, the byte is sent.
- R9: When `flow_en_i`=1, a frame starts only while `cts_i`=1 (active high). Dropping `cts_i` during a frame does not cut that frame short.
- R10: `stat_o[1]` is 1 when the holding register is empty. `stat_o[0]` is 1 only when both the holding register and the shifter are empty. When the holding register is empty, a byte written while a frame is shifting is accepted.
- R11: A write while the holding register is full is dropped. Only the byte already held is sent.
- R12: The format inputs (length, parity, stop count) are captured when a frame starts. Changing them during the frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| len_code_i | input | 2 | Data length code (see R3) |
| par_en_i | input | 1 | Parity enable |
| par_odd_i | input | 1 | Odd parity select |
| two_stop_i | input | 1 | Two stop bits when 1 |
| out_en_i | input | 1 | Serial output enable |
| tx_en_i | input | 1 | Transmit enable gate |
| flow_en_i | input | 1 | Clear-to-send gating enable |
| cts_i | input | 1 | Clear to send, active high |
| div_i | input | DIV_W | Bit period minus one, in clocks |
| wr_valid_i | input | 1 | Write strobe for the holding register |
| wr_data_i | input | 8 | Byte to send |
| txd_o | output | 1 | Serial data line |
| txd_oe_o | output | 1 | Serial line output enable |
| stat_o | output | 2 | Bit 1 holding empty, bit 0 transmit idle |

## Verification
The hardest states to reach from the ports are those where a byte waits in the holding register while frames are held back. These are a write that arrives while the holding register is still full, and a clear-to-send drop that lands in the middle of a frame. The stimulus parks a byte with the transmit gate closed, then writes a second byte so that it must be dropped. It then opens the gate and confirms that exactly one frame comes out. A second sequence starts a frame under clear-to-send gating and withdraws the grant a few cycles into it. A third sequence changes the format inputs mid-frame. In each case the serial line is sampled at the middle of every bit period and compared against a frame built independently in the bench.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  localparam int DATA_MAX  = 8;
  localparam int FRAME_MAX = DATA_MAX + 4;
  localparam int CNT_W     = $clog2(FRAME_MAX + 1);

  typedef struct packed {
    logic [1:0] len_code;
    logic       par_en;
    logic       par_odd;
    logic       two_stop;
  } fmt_t;

  // Number of data bits for a length code: 0 is the full byte, 1..3 give 5..7.
  function automatic int data_len(input logic [1:0] code);
    return (code == 2'd0) ? DATA_MAX : (4 + int'(code));
  endfunction

  // Parity over the first n data bits; odd selects the inverted sense.
  function automatic logic par_calc(input logic [DATA_MAX-1:0] d, input int n,
                                    input logic odd);
    logic p;
    p = odd;
    for (int i = 0; i < DATA_MAX; i++) begin
      if (i < n) p = p ^ d[i];
    end
    return p;
  endfunction

  // Total frame bits: start + data + optional parity + one or two stops.
  function automatic logic [CNT_W-1:0] frame_len(input fmt_t f);
    int n;
    n = 2 + data_len(f.len_code) + int'(f.par_en) + int'(f.two_stop);
    return CNT_W'(n);
  endfunction

  // Frame image, bit 0 leaves first; unused high positions stay at 1.
  function automatic logic [FRAME_MAX-1:0] frame_image(input logic [DATA_MAX-1:0] d,
                                                       input fmt_t f);
    logic [FRAME_MAX-1:0] img;
    int n;
    n   = data_len(f.len_code);
    img = '1;
    img[0] = 1'b0;
    for (int i = 0; i < DATA_MAX; i++) begin
      if (i < n) img[i+1] = d[i];
    end
    for (int i = 5; i <= DATA_MAX; i++) begin
      if (i == n && f.par_en) img[i+1] = par_calc(d, n, f.par_odd);
    end
    return img;
  endfunction

endpackage

// File: rtl/sertx_hold.sv
module sertx_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          take_i,
  output logic          full_o,
  output logic [DW-1:0] data_o
);

  logic          full_q;
  logic [DW-1:0] data_q;
  logic          accept;

  assign accept = wr_valid_i && !full_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (accept) begin
      full_q <= 1'b1;
      data_q <= wr_data_i;
    end else if (take_i) begin
      full_q <= 1'b0;
    end
  end

  assign full_o = full_q;
  assign data_o = data_q;

  // R11: a held byte is neither replaced nor lost until the shifter takes it
  assert_held_byte_R11: assert property (@(posedge clk) disable iff (!rst_n)
    full_q && !take_i |=> full_q && $stable(data_q));

  // R10: the shifter only takes from a full holding register
  assert_take_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |-> full_q);

endmodule

// File: rtl/sertx_baud.sv
module sertx_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart_i,
  input  logic             busy_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_q;

  assign tick_o = busy_i && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart_i || tick_o) begin
      cnt_q <= div_i;
    end else if (busy_i) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
  import sertx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_i,
  input  logic [DATA_MAX-1:0] data_i,
  input  fmt_t                fmt_i,
  input  logic                tick_i,
  output logic                busy_o,
  output logic                line_o
);

  logic [FRAME_MAX-1:0] sh_q;
  logic [CNT_W-1:0]     left_q;
  logic                 busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      left_q <= '0;
      busy_q <= 1'b0;
    end else if (load_i) begin
      sh_q   <= frame_image(data_i, fmt_i);
      left_q <= frame_len(fmt_i);
      busy_q <= 1'b1;
    end else if (tick_i) begin
      sh_q   <= {1'b1, sh_q[FRAME_MAX-1:1]};
      left_q <= left_q - 1'b1;
      if (left_q == CNT_W'(1)) busy_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign line_o = sh_q[0];

  // R2: a frame opens with the low start bit
  assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> busy_q && !line_o);

  // R2: idle level is high
  assert_idle_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> line_o);

  // R6: the line only changes at a bit boundary from the baud timer
  assert_bit_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !tick_i |=> $stable(line_o));

endmodule

// File: rtl/sertx_core.sv
module sertx_core
  import sertx_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          len_code_i,
  input  logic                par_en_i,
  input  logic                par_odd_i,
  input  logic                two_stop_i,
  input  logic                out_en_i,
  input  logic                tx_en_i,
  input  logic                flow_en_i,
  input  logic                cts_i,
  input  logic [DIV_W-1:0]    div_i,
  input  logic                wr_valid_i,
  input  logic [DATA_MAX-1:0] wr_data_i,
  output logic                txd_o,
  output logic                txd_oe_o,
  output logic [1:0]          stat_o
);

  fmt_t                fmt;
  logic                hold_full;
  logic [DATA_MAX-1:0] hold_data;
  logic                busy;
  logic                tick;
  logic                line;
  logic                start_ev;
  logic                gate_open;

  assign fmt       = '{len_code: len_code_i, par_en: par_en_i,
                       par_odd: par_odd_i, two_stop: two_stop_i};
  assign gate_open = tx_en_i && (!flow_en_i || cts_i);
  assign start_ev  = hold_full && !busy && gate_open;

  sertx_hold #(.DW(DATA_MAX)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_valid_i (wr_valid_i),
    .wr_data_i  (wr_data_i),
    .take_i     (start_ev),
    .full_o     (hold_full),
    .data_o     (hold_data)
  );

  sertx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (start_ev),
    .busy_i    (busy),
    .div_i     (div_i),
    .tick_o    (tick)
  );

  sertx_shift u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (start_ev),
    .data_i (hold_data),
    .fmt_i  (fmt),
    .tick_i (tick),
    .busy_o (busy),
    .line_o (line)
  );

  assign txd_o    = out_en_i ? line : 1'b1;
  assign txd_oe_o = out_en_i;
  assign stat_o   = {!hold_full, !hold_full && !busy};

  // R8: a frame begins only with the transmit gate open
  assert_start_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(tx_en_i));

  // R9: with gating on, a frame begins only under clear-to-send
  assert_cts_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) && $past(flow_en_i) |-> $past(cts_i));

  // R10: the holding register fills only through a write
  assert_fill_by_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat_o[1]) |-> $past(wr_valid_i));

endmodule

// File: tb/sertx_core_tb.sv
module sertx_core_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  len_code;
  logic        par_en, par_odd, two_stop, out_en, tx_en, flow_en, cts;
  logic [15:0] div;
  logic        wr_valid;
  logic [7:0]  wr_data;
  logic        txd_o, txd_oe_o;
  logic [1:0]  stat_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  sertx_core #(.DIV_W(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .len_code_i(len_code), .par_en_i(par_en),
    .par_odd_i(par_odd), .two_stop_i(two_stop), .out_en_i(out_en),
    .tx_en_i(tx_en), .flow_en_i(flow_en), .cts_i(cts), .div_i(div),
    .wr_valid_i(wr_valid), .wr_data_i(wr_data), .txd_o(txd_o),
    .txd_oe_o(txd_oe_o), .stat_o(stat_o)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Frame built from the requirement text, bit 0 first on the line.
  function automatic logic [11:0] ref_frame(input logic [7:0] d, input int lc,
                                            input bit pe, input bit po,
                                            input bit ts, output int n);
    logic [11:0] f;
    int nd, pos, ones;
    nd = (lc == 0) ? 8 : lc + 4;
    f = '1;
    f[0] = 1'b0;
    ones = 0;
    for (int i = 0; i < nd; i++) begin
      f[i+1] = d[i];
      ones += int'(d[i]);
    end
    pos = nd + 1;
    if (pe) begin
      f[pos] = po ? ((ones % 2) == 0) : ((ones % 2) == 1);
      pos++;
    end
    n = pos + 1 + int'(ts);
    return f;
  endfunction

  task automatic write_byte(input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  // Waits for a start bit, samples each bit mid-period, optionally times the frame.
  task automatic capture(input int n, input int d, input bit chk_len,
                         output logic [11:0] bits, output int endk);
    int k;
    int guard;
    bits = '1;
    endk = -1;
    guard = 0;
    while (txd_o !== 1'b0 && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    if (guard >= 5000) begin
      bits = 'x;
    end else begin
      k = 0;
      for (int i = 0; i < n; i++) begin
        while (k < i * (d + 1) + (d + 1) / 2) begin
          @(negedge clk);
          k++;
        end
        bits[i] = txd_o;
      end
      if (chk_len) begin
        while (stat_o[0] !== 1'b1 && k < 20000) begin
          @(negedge clk);
          k++;
        end
        endk = k;
      end
    end
  endtask

  task automatic set_fmt(input int lc, input bit pe, input bit po, input bit ts,
                         input int d);
    len_code = 2'(lc);
    par_en   = pe;
    par_odd  = po;
    two_stop = ts;
    div      = 16'(d);
  endtask

  task automatic run_frame(input logic [7:0] d, input int lc, input bit pe,
                           input bit po, input bit ts, input int dv,
                           input string req);
    logic [11:0] exp, got, mask;
    int n, endk;
    set_fmt(lc, pe, po, ts, dv);
    exp = ref_frame(d, lc, pe, po, ts, n);
    mask = 12'((1 << n) - 1);
    write_byte(d);
    capture(n, dv, 1'b1, got, endk);
    check((got & mask) === (exp & mask), req, 32'(got & mask), 32'(exp & mask));
    check(endk == n * (dv + 1), {req, " R6 frame time"}, 32'(endk), 32'(n * (dv + 1)));
  endtask

  task automatic t_reset;
    // R1
    check(txd_o === 1'b1, "R1 txd", 32'(txd_o), 32'd1);
    check(stat_o === 2'b11, "R1 status", 32'(stat_o), 32'd3);
  endtask

  task automatic t_formats;
    run_frame(8'hA5, 0, 1'b0, 1'b0, 1'b0, 3, "R2 R3 8N1");
    run_frame(8'hF3, 1, 1'b1, 1'b0, 1'b0, 0, "R3 R4 5E1 div0");
    run_frame(8'h2D, 2, 1'b1, 1'b1, 1'b1, 2, "R4 R5 6O2");
    run_frame(8'hC9, 3, 1'b0, 1'b0, 1'b1, 7, "R3 R5 7N2");
    run_frame(8'h16, 0, 1'b1, 1'b1, 1'b0, 12, "R4 R6 8O1 div12");
  endtask

  task automatic t_out_enable;
    int k, n;
    bit all_high;
    logic [11:0] unused_f;
    set_fmt(0, 1'b0, 1'b0, 1'b0, 1);
    out_en = 1'b0;
    @(negedge clk);
    check(txd_oe_o === 1'b0, "R7 oe low", 32'(txd_oe_o), 32'd0);
    unused_f = ref_frame(8'h00, 0, 1'b0, 1'b0, 1'b0, n);
    write_byte(8'h00);
    k = 0;
    all_high = 1'b1;
    while (stat_o[0] !== 1'b1 && k < 5000) begin
      if (txd_o !== 1'b1) all_high = 1'b0;
      @(negedge clk);
      k++;
    end
    check(all_high, "R7 line quiet", 32'(all_high), 32'd1);
    check(k == n * 2 + 1, "R7 frame still runs", 32'(k), 32'(n * 2 + 1));
    out_en = 1'b1;
    @(negedge clk);
    check(txd_oe_o === 1'b1, "R7 oe high", 32'(txd_oe_o), 32'd1);
  endtask

  task automatic t_enable_drop;
    logic [11:0] exp, got;
    int n, endk;
    bit all_high;
    set_fmt(0, 1'b0, 1'b0, 1'b0, 2);
    tx_en = 1'b0;
    write_byte(8'h5B);
    write_byte(8'h3C);   // R11: holding register full, must be dropped
    all_high = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (txd_o !== 1'b1) all_high = 1'b0;
    end
    check(all_high, "R8 held while disabled", 32'(all_high), 32'd1);
    check(stat_o === 2'b00, "R8 R10 status while held", 32'(stat_o), 32'd0);
    tx_en = 1'b1;
    exp = ref_frame(8'h5B, 0, 1'b0, 1'b0, 1'b0, n);
    capture(n, 2, 1'b1, got, endk);
    check((got & 12'h3FF) === (exp & 12'h3FF), "R8 R11 first byte sent",
          32'(got & 12'h3FF), 32'(exp & 12'h3FF));
    all_high = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (txd_o !== 1'b1) all_high = 1'b0;
    end
    check(all_high && stat_o === 2'b11, "R11 no second frame",
          {30'd0, stat_o}, 32'd3);
  endtask

  task automatic t_flow;
    logic [11:0] exp, got;
    int n, endk;
    bit all_high;
    set_fmt(0, 1'b0, 1'b0, 1'b0, 3);
    flow_en = 1'b1;
    cts = 1'b0;
    write_byte(8'h81);
    all_high = 1'b1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (txd_o !== 1'b1) all_high = 1'b0;
    end
    check(all_high && stat_o === 2'b00, "R9 blocked without cts",
          {30'd0, stat_o}, 32'd0);
    cts = 1'b1;
    exp = ref_frame(8'h81, 0, 1'b0, 1'b0, 1'b0, n);
    fork
      capture(n, 3, 1'b1, got, endk);
      begin
        repeat (6) @(negedge clk);
        cts = 1'b0;
      end
    join
    check((got & 12'h3FF) === (exp & 12'h3FF), "R9 frame completes",
          32'(got & 12'h3FF), 32'(exp & 12'h3FF));
    check(endk == n * 4, "R9 frame time", 32'(endk), 32'(n * 4));
    flow_en = 1'b0;
    cts = 1'b1;
  endtask

  task automatic t_back_to_back;
    logic [11:0] ea, eb, ga, gb;
    int n, endk, unused_k;
    set_fmt(0, 1'b1, 1'b0, 1'b0, 7);
    ea = ref_frame(8'h6E, 0, 1'b1, 1'b0, 1'b0, n);
    eb = ref_frame(8'h93, 0, 1'b1, 1'b0, 1'b0, n);
    write_byte(8'h6E);
    fork
      capture(n, 7, 1'b0, ga, unused_k);
      begin
        @(negedge clk);
        check(stat_o === 2'b10, "R10 empty holding while shifting",
              32'(stat_o), 32'd2);
        write_byte(8'h93);
      end
    join
    capture(n, 7, 1'b1, gb, endk);
    check((ga & 12'h7FF) === (ea & 12'h7FF), "R10 first of pair",
          32'(ga & 12'h7FF), 32'(ea & 12'h7FF));
    check((gb & 12'h7FF) === (eb & 12'h7FF), "R10 second of pair",
          32'(gb & 12'h7FF), 32'(eb & 12'h7FF));
    check(endk == n * 8, "R10 second frame time", 32'(endk), 32'(n * 8));
  endtask

  task automatic t_format_latch;
    logic [11:0] exp, got;
    int n, endk;
    set_fmt(0, 1'b0, 1'b0, 1'b0, 3);
    exp = ref_frame(8'hB4, 0, 1'b0, 1'b0, 1'b0, n);
    write_byte(8'hB4);
    fork
      capture(n, 3, 1'b1, got, endk);
      begin
        repeat (6) @(negedge clk);
        len_code = 2'd1;
        par_en   = 1'b1;
        two_stop = 1'b1;
      end
    join
    check((got & 12'h3FF) === (exp & 12'h3FF), "R12 format held",
          32'(got & 12'h3FF), 32'(exp & 12'h3FF));
    check(endk == n * 4, "R12 frame time", 32'(endk), 32'(n * 4));
  endtask

  initial begin
    #(20 * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    set_fmt(0, 1'b0, 1'b0, 1'b0, 3);
    out_en = 1'b1;
    tx_en = 1'b1;
    flow_en = 1'b0;
    cts = 1'b1;
    wr_valid = 1'b0;
    wr_data = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_formats();
    t_out_enable();
    t_enable_drop();
    t_flow();
    t_back_to_back();
    t_format_latch();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule